// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from three sources for a small processor core: a USB event, a timer 0 overflow and a timer 1 overflow. Each request is captured in a sticky flag. A call toward the core is raised only when four things hold at once: the global enable is set, the source's own enable is set, the flag is set, and the core reports room on its return stack. The call carries a fixed vector address. When a call is taken, the serviced flag and the global enable both clear, so the core runs its handler unmasked by nothing else until it returns with the enable-restoring form of return.

Arbitration is not evaluated on every clock. It happens only in cycles where the sampling strobe is high, so a request that arrives between two strobes is acted on at the later strobe. All enables and flags share one control register on a simple write/read port. Software can set or clear any flag through that port, and setting a flag raises a request like a hardware event would.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0, `call_req_o` is 0 and `call_vec_o` is 0.
- R2: The control register is 7 bits wide. Bit 0 is the global enable. Bits 1, 2 and 3 enable the USB, timer 0 and timer 1 sources. Bits 4, 5 and 6 are the USB, timer 0 and timer 1 flags. A write replaces all seven bits, including the flags, and the new value is readable in the cycle after the write edge.
- R3: An event pulse on `src_evt_i[i]` (bit 0 USB, bit 1 timer 0, bit 2 timer 1) sets flag i at the next edge. The flag stays set until that source is taken or software writes it to 0.
- R4: A call is taken only at an edge where `sample_stb_i` is high. Flags pending while the strobe is low raise no call until the next strobe edge.
- R5: A call is taken only when the global enable, the source enable and its flag are all 1 and `stack_full_i` is 0. Otherwise no call is raised.
- R6: Among eligible sources the lowest index wins. The vector is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1.
- R7: At the edge that takes a call, the flag of the chosen source and the global enable both clear. All other flags and enables are unchanged.
- R8: `call_req_o` and `call_vec_o` stay constant until a cycle with `call_ack_i` high. At the edge after that cycle both return to 0. No new call is taken while one is outstanding.
- R9: A return with `ret_i` and `ret_en_i` both high sets the global enable. A return with `ret_en_i` low leaves it unchanged.
- R10: Several updates can land at the same edge. A hardware event sets its flag even when that source is taken or written at the same edge. Taking a call clears the global enable even when a write or an enabling return sets it at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 3 | Event pulses: bit 0 USB, bit 1 timer 0, bit 2 timer 1 |
| sample_stb_i | input | 1 | Sampling phase strobe; arbitration happens only when high |
| stack_full_i | input | 1 | Core return stack is full; blocks calls |
| reg_we_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 7 | Write data for the control register |
| reg_rdata_o | output | 7 | Current control register value |
| call_req_o | output | 1 | Vectored call request to the core |
| call_vec_o | output | 8 | Vector address of the outstanding call, 0 when none |
| call_ack_i | input | 1 | Core accepts the outstanding call |
| ret_i | input | 1 | Core executes a return from interrupt |
| ret_en_i | input | 1 | Qualifies `ret_i` as the enable-restoring return |

## Verification
The bench targets the cycles where updates collide. One case is an event on the very source being taken, where a design that lets the clear win would silently lose a request. Another is a write setting the global enable on the edge that takes a call, where the wrong precedence leaves interrupts unmasked inside the handler. A third is a burst of pending flags drained one at a time, which exposes inverted priority or wrong vector offsets. It also strobes repeatedly while a call is unacknowledged, so a design that re-arbitrates would change the vector or eat a second flag. Plain returns, full stacks and strobe-less cycles are mixed into a long pseudo-random run, and a behavioural model flags any call raised off-phase or while blocked.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NSRC     = 3;
    localparam int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 4;
    localparam int VEC_STEP = 4;

    localparam int GIE_BIT  = 0;
    localparam int EN_LSB   = GIE_BIT + 1;
    localparam int FLAG_LSB = EN_LSB + NSRC;
    localparam int REG_W    = FLAG_LSB + NSRC;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
    } call_t;

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic            gie;
    } ctrl_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx,
                                                 input int base,
                                                 input int step);
        return VEC_W'(base + step * int'(idx));
    endfunction

endpackage

// File: rtl/irqv_flags.sv
module irqv_flags #(
    parameter int N = irqv_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic         wr,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] flags
);
    // Per-source sticky bit: event beats take-clear beats software write.
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
            else if (wr)
                flags[i] <= wr_val[i];
        end
    end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int N = irqv_pkg::NSRC
) (
    input  logic [N-1:0] pend,
    output pick_t        pick
);
    // Fixed priority: lowest index wins, so scan from the top down.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_call.sv
module irqv_call
    import irqv_pkg::*;
#(
    parameter int VBASE = irqv_pkg::VEC_BASE,
    parameter int VSTEP = irqv_pkg::VEC_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    input  logic             ack,
    output call_t            call
);
    always_ff @(posedge clk) begin
        if (rst)
            call <= '0;
        else if (call.req && ack)
            call <= '0;
        else if (take) begin
            call.req <= 1'b1;
            call.vec <= vec_of(take_idx, VBASE, VSTEP);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int VBASE = irqv_pkg::VEC_BASE,
    parameter int VSTEP = irqv_pkg::VEC_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_evt_i,
    input  logic             sample_stb_i,
    input  logic             stack_full_i,
    input  logic             reg_we_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             call_req_o,
    output logic [VEC_W-1:0] call_vec_o,
    input  logic             call_ack_i,
    input  logic             ret_i,
    input  logic             ret_en_i
);
    ctrl_t           wr_ctrl;
    ctrl_t           cur;
    logic            gie_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] clr;
    pick_t           pick;
    call_t           call;
    logic            take;

    assign wr_ctrl = ctrl_t'(reg_wdata_i);

    // Arbitration only on the sampling phase, with no call outstanding.
    assign take = sample_stb_i && !call.req && gie_q && !stack_full_i && pick.hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign clr[i] = take && (pick.idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (reg_we_i)
            en_q <= wr_ctrl.en;
    end

    // Global enable: take-clear beats enabling return beats software write.
    always_ff @(posedge clk) begin
        if (rst)
            gie_q <= 1'b0;
        else if (take)
            gie_q <= 1'b0;
        else if (ret_i && ret_en_i)
            gie_q <= 1'b1;
        else if (reg_we_i)
            gie_q <= wr_ctrl.gie;
    end

    irqv_flags #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (src_evt_i),
        .clr    (clr),
        .wr     (reg_we_i),
        .wr_val (wr_ctrl.flag),
        .flags  (flags)
    );

    irqv_prio #(.N(NSRC)) u_prio (
        .pend (flags & en_q),
        .pick (pick)
    );

    irqv_call #(.VBASE(VBASE), .VSTEP(VSTEP)) u_call (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_idx (pick.idx),
        .ack      (call_ack_i),
        .call     (call)
    );

    always_comb begin
        cur.flag = flags;
        cur.en   = en_q;
        cur.gie  = gie_q;
    end

    assign reg_rdata_o = REG_W'(cur);
    assign call_req_o  = call.req;
    assign call_vec_o  = call.vec;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter int VBASE = irqv_pkg::VEC_BASE,
    parameter int VSTEP = irqv_pkg::VEC_STEP
) (
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  src_evt_i,
    input logic             sample_stb_i,
    input logic             stack_full_i,
    input logic             reg_we_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             call_req_o,
    input logic [VEC_W-1:0] call_vec_o,
    input logic             call_ack_i,
    input logic             ret_i,
    input logic             ret_en_i
);
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (src_evt_i != '0) |=> ((reg_rdata_o[FLAG_LSB +: NSRC] & $past(src_evt_i)) == $past(src_evt_i))); // R3

    AST_CALL_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(call_req_o) |-> ($past(sample_stb_i) && !$past(stack_full_i))); // R4

    AST_CALL_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        $rose(call_req_o) |-> $past(reg_rdata_o[GIE_BIT])); // R5

    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (rst)
        $rose(call_req_o) |-> !reg_rdata_o[GIE_BIT]); // R7

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        call_req_o |-> (int'(call_vec_o) >= VBASE
                        && int'(call_vec_o) < VBASE + VSTEP * NSRC
                        && ((int'(call_vec_o) - VBASE) % VSTEP) == 0)); // R6

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (call_req_o && !call_ack_i) |=> (call_req_o && $stable(call_vec_o))); // R8

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (call_req_o && call_ack_i) |=> (!call_req_o && call_vec_o == '0)); // R8

    AST_RET_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (ret_i && ret_en_i && !reg_we_i) |=> (reg_rdata_o[GIE_BIT] || $rose(call_req_o))); // R9

endmodule

bind irq_vector_ctrl irqv_checker #(.VBASE(VBASE), .VSTEP(VSTEP)) u_chk (.*);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt = '0;
    logic       stb = 1'b0;
    logic       sfull = 1'b0;
    logic       we = 1'b0;
    logic [6:0] wd = '0;
    logic [6:0] rdata;
    logic       creq;
    logic [7:0] cvec;
    logic       ack = 1'b0;
    logic       ret = 1'b0;
    logic       reten = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit wd_hit = 1'b0;
    string cur_req = "R1";

    // reference state
    bit       m_gie;
    bit [2:0] m_en;
    bit [2:0] m_flag;
    bit       m_req;
    bit [7:0] m_vec;

    always #2 clk = ~clk;

    irq_vector_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .src_evt_i    (evt),
        .sample_stb_i (stb),
        .stack_full_i (sfull),
        .reg_we_i     (we),
        .reg_wdata_i  (wd),
        .reg_rdata_o  (rdata),
        .call_req_o   (creq),
        .call_vec_o   (cvec),
        .call_ack_i   (ack),
        .ret_i        (ret),
        .ret_en_i     (reten)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit [2:0] pend;
        bit       take;
        int       sel;
        bit [2:0] nflag;
        bit       ngie;
        pend = m_flag & m_en;
        take = stb && !m_req && m_gie && !sfull && (pend != 0);
        sel = 0;
        for (int i = 2; i >= 0; i--) if (pend[i]) sel = i;
        nflag = we ? wd[6:4] : m_flag;
        if (take) nflag[sel] = 1'b0;
        nflag = nflag | evt;
        ngie = we ? wd[0] : m_gie;
        if (ret && reten) ngie = 1'b1;
        if (take) ngie = 1'b0;
        if (we) m_en = wd[3:1];
        m_flag = nflag;
        m_gie = ngie;
        if (take) begin
            m_req = 1'b1;
            m_vec = 8'(4 + 4 * sel);
        end else if (m_req && ack) begin
            m_req = 1'b0;
            m_vec = 8'h00;
        end
    endtask

    // one clock: model at the edge, compare at the falling edge, clear pulses
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(cur_req, "rdata", 32'(rdata), 32'({m_flag, m_en, m_gie}));
        chk(cur_req, "call_req", 32'(creq), 32'(m_req));
        chk(cur_req, "call_vec", 32'(cvec), 32'(m_vec));
        evt = '0; stb = 1'b0; we = 1'b0; ack = 1'b0; ret = 1'b0; reten = 1'b0;
    endtask

    task automatic wr(input logic [6:0] v);
        we = 1'b1; wd = v; tick();
    endtask

    task automatic run_tests();
        int lfsr;
        // R1: reset
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_gie = 0; m_en = 0; m_flag = 0; m_req = 0; m_vec = 0;
        chk("R1", "rdata", 32'(rdata), 32'h0);
        chk("R1", "call_req", 32'(creq), 32'h0);
        chk("R1", "call_vec", 32'(cvec), 32'h0);

        cur_req = "R2";
        wr(7'h2A);
        chk("R2", "layout", 32'(rdata), 32'h2A);
        wr(7'h00);
        chk("R2", "clear", 32'(rdata), 32'h00);

        cur_req = "R3";
        evt = 3'b100; tick();
        chk("R3", "t1 flag bit6", 32'(rdata), 32'h40);
        repeat (3) tick();
        chk("R3", "sticky", 32'(rdata), 32'h40);
        evt = 3'b001; tick();
        chk("R3", "usb flag", 32'(rdata), 32'h50);

        cur_req = "R4";
        wr(7'h0F);
        evt = 3'b010; tick();
        tick(); tick();
        chk("R4", "no call off strobe", 32'(creq), 32'h0);
        stb = 1'b1; tick();
        chk("R4", "call at strobe", 32'(creq), 32'h1);
        chk("R4", "t0 vector", 32'(cvec), 32'h08);
        chk("R7", "after take", 32'(rdata), 32'h0E);
        ack = 1'b1; tick();
        chk("R8", "ack release", 32'(creq), 32'h0);

        cur_req = "R5";
        wr(7'h7F);
        sfull = 1'b1; stb = 1'b1; tick();
        chk("R5", "stack full", 32'(creq), 32'h0);
        sfull = 1'b0;
        wr(7'h71);
        stb = 1'b1; tick();
        chk("R5", "sources off", 32'(creq), 32'h0);
        wr(7'h7E);
        stb = 1'b1; tick();
        chk("R5", "gie off", 32'(creq), 32'h0);

        cur_req = "R6";
        wr(7'h7F);
        stb = 1'b1; tick();
        chk("R6", "usb first", 32'(cvec), 32'h04);
        chk("R7", "others kept", 32'(rdata), 32'h6E);
        ack = 1'b1; tick();
        ret = 1'b1; reten = 1'b1; tick();
        chk("R9", "reti sets gie", 32'(rdata), 32'h6F);
        stb = 1'b1; tick();
        chk("R6", "t0 second", 32'(cvec), 32'h08);
        ack = 1'b1; tick();
        ret = 1'b1; reten = 1'b1; tick();
        stb = 1'b1; tick();
        chk("R6", "t1 third", 32'(cvec), 32'h0C);
        chk("R7", "all drained", 32'(rdata), 32'h0E);

        cur_req = "R8";
        wr(7'h7F);
        for (int k = 0; k < 3; k++) begin
            stb = 1'b1; tick();
        end
        chk("R8", "held vec", 32'(cvec), 32'h0C);
        chk("R8", "no re-arbitration", 32'(rdata), 32'h7F);
        ack = 1'b1; tick();
        chk("R8", "vec zero", 32'(cvec), 32'h00);
        stb = 1'b1; tick();
        chk("R8", "next call", 32'(cvec), 32'h04);
        ack = 1'b1; tick();

        cur_req = "R9";
        ret = 1'b1; reten = 1'b0; tick();
        chk("R9", "plain ret", 32'(rdata[0]), 32'h0);
        ret = 1'b1; reten = 1'b1; tick();
        chk("R9", "ret enables", 32'(rdata[0]), 32'h1);

        cur_req = "R10";
        wr(7'h7F);
        stb = 1'b1; evt = 3'b001; tick();
        chk("R10", "event beats clear", 32'(rdata), 32'h7E);
        chk("R10", "vec", 32'(cvec), 32'h04);
        ack = 1'b1; tick();
        ret = 1'b1; reten = 1'b1; tick();
        stb = 1'b1; we = 1'b1; wd = 7'h1F; tick();
        chk("R10", "take beats write", 32'(rdata), 32'h0E);
        ack = 1'b1; tick();

        // mixed pseudo-random traffic against the model
        cur_req = "R6";
        lfsr = 32'h1ACE5;
        for (int k = 0; k < 600; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 0);
            evt   = ((lfsr & 32'h7) == 0) ? 3'(lfsr >> 4) : 3'b000;
            stb   = ((lfsr >> 8) & 3) == 0;
            sfull = ((lfsr >> 10) & 7) == 0;
            ack   = ((lfsr >> 13) & 3) == 0;
            ret   = ((lfsr >> 15) & 7) == 0;
            reten = ((lfsr >> 18) & 1) != 0;
            we    = ((lfsr >> 19) & 31) == 0;
            wd    = 7'(lfsr >> 24);
            tick();
        end
        sfull = 1'b0;
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired during %s actual=hung expected=done", cur_req);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule